// File: doc/BRIEF.md
# Auto-Reload Multi-Block DMA Sequencer

This block runs one DMA channel that copies a run of equal-sized blocks from a source region to a destination region, one word at a time. Software programs the two start addresses, the block length and a control word through a small register write port. For each word, the sequencer reads from the source address and then, on the next cycle, writes the captured data to the destination address.

At every block boundary, each address either restarts from its programmed start value or carries on from where it stopped. A separate reload bit selects this for the source and for the destination. With either bit set, the channel keeps starting new blocks. At the end of a block, if both bits are found clear, that block was the last one: the channel reports completion and goes idle.

A block-complete interrupt is raised at every block end while interrupts are enabled. If the block-complete mask bit also unmasks it, the channel waits between blocks until software writes the interrupt-clear register. Otherwise it starts the next block at once. Clearing the enable bit stops the channel after the word currently in flight.

Top module: `dma_reload_seq`

## Requirements
- R1: After reset, mem_rd_o, mem_wr_o, irq_o and done_o are low, and no bus access occurs until software sets the enable bit.
- R2: Each word is a read cycle (mem_rd_o high, mem_addr_o = source pointer), followed on the next cycle by a write cycle (mem_wr_o high, mem_addr_o = destination pointer, mem_wdata_o = the data read). Both pointers advance by one word address per word, and a block holds (length register + 1) words.
- R3: The register addresses are 0 for source start, 1 for destination start, 2 for length (words minus one), 3 for control and 4 for interrupt clear. Writing control with bit 0 (enable) set while idle starts the channel, and the first block always uses the programmed start addresses.
- R4: With control bit 1 (source reload) set at a block end, the next block reads again from the source start address. With it clear, the source pointer continues from the following address.
- R5: With control bit 2 (destination reload) set at a block end, the next block writes again from the destination start address. With it clear, the destination pointer continues from the following address.
- R6: When both reload bits are clear at a block end, done_o is high for exactly one cycle after the final write, the enable bit is cleared, and no further access occurs.
- R7: With control bit 3 (interrupt enable) and bit 4 (unmask) both set, no bus access occurs after a non-final block end until a write to the interrupt-clear register. The next block's first read follows in the cycle after that write is sampled.
- R8: With bit 3 or bit 4 clear, the first read of the next block comes in the cycle right after the previous block's last write.
- R9: With interrupt enable set, irq_o rises at every block end and stays high until an interrupt-clear write, whether or not the channel stalls. A clear write sampled in the same cycle as a block end leaves irq_o high.
- R10: Clearing the enable bit during a block lets the word in flight finish its write. After that there is no further access and no done_o pulse.
- R11: The reload bits are sampled only at a block end. Clearing them while a block is in flight makes that same block the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| mem_addr_o | output | ADDR_W | Word address of the current access |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_rdata_i | input | DATA_W | Read data, valid during the read cycle |
| mem_wdata_o | output | DATA_W | Write data |
| irq_o | output | 1 | Block-complete interrupt |
| done_o | output | 1 | One-cycle transfer-complete pulse |

## Verification
The interrupt-clear write and the hardware setting of the block-complete interrupt can land in the same clock cycle. The bench provokes this with interrupts enabled but unmasked off, so that blocks run back to back. It watches the write strobes to find the last write of a block and drives the clear write in exactly that cycle. irq_o must then still be high on the following cycle, while the next block's first read goes ahead, and an earlier clear written in mid-block must have dropped irq_o.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] REG_SRC  = 3'd0;
  localparam logic [REG_AW-1:0] REG_DST  = 3'd1;
  localparam logic [REG_AW-1:0] REG_LEN  = 3'd2;
  localparam logic [REG_AW-1:0] REG_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] REG_ICLR = 3'd4;

  localparam int unsigned CTRL_W = 5;

  // bit 0 en, 1 src reload, 2 dst reload, 3 irq enable, 4 unmask
  typedef struct packed {
    logic unmask;
    logic int_en;
    logic rl_dst;
    logic rl_src;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_STALL} state_e;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              en_clr_i,
  input  logic              blk_end_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] src_init_o,
  output logic [ADDR_W-1:0] dst_init_o,
  output logic [LEN_W-1:0]  len_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_init_o <= '0;
      dst_init_o <= '0;
      len_o      <= '0;
    end else if (we_i) begin
      if (addr_i == REG_SRC) src_init_o <= wdata_i[ADDR_W-1:0];
      if (addr_i == REG_DST) dst_init_o <= wdata_i[ADDR_W-1:0];
      if (addr_i == REG_LEN) len_o      <= wdata_i[LEN_W-1:0];
    end
  end

  // software write wins over hardware enable clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (we_i && addr_i == REG_CTRL) ctrl_o <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    else if (en_clr_i) ctrl_o.en <= 1'b0;
  end

  // set at block end wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else if (blk_end_i && ctrl_o.int_en) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  assert_irq_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_i && ctrl_o.int_en |=> irq_o);
endmodule

// File: rtl/dma_seq_ptr.sv
module dma_seq_ptr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              next_i,
  input  logic              reload_i,
  input  logic [ADDR_W-1:0] init_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else if (load_i) ptr_o <= init_i;
    else if (next_i) ptr_o <= reload_i ? init_i : ptr_o + 1'b1;
    else if (step_i) ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              load_o,
  output logic              step_o,
  output logic              next_o,
  output logic              blk_end_o,
  output logic              en_clr_o,
  output logic              done_o
);
  state_e            state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              done_d;
  logic              last_word;

  assign last_word = (cnt_q == len_i);
  assign rd_o      = (state_q == ST_READ);
  assign wr_o      = (state_q == ST_WRITE);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    load_o    = 1'b0;
    step_o    = 1'b0;
    next_o    = 1'b0;
    blk_end_o = 1'b0;
    en_clr_o  = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ctrl_i.en) begin
        load_o  = 1'b1;
        cnt_d   = '0;
        state_d = ST_READ;
      end
      ST_READ: state_d = ST_WRITE;
      ST_WRITE: begin
        if (!ctrl_i.en) begin
          state_d = ST_IDLE;          // abort at word boundary
        end else if (last_word) begin
          blk_end_o = 1'b1;
          cnt_d     = '0;
          if (!ctrl_i.rl_src && !ctrl_i.rl_dst) begin
            en_clr_o = 1'b1;
            done_d   = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            next_o  = 1'b1;
            state_d = (ctrl_i.int_en && ctrl_i.unmask) ? ST_STALL : ST_READ;
          end
        end else begin
          step_o  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_READ;
        end
      end
      ST_STALL: begin
        if (!ctrl_i.en) state_d = ST_IDLE;
        else if (clr_i) state_d = ST_READ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      wdata_o <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_o  <= done_d;
      if (rd_o) wdata_o <= rdata_i;
    end
  end

  assert_write_follows_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o));
  assert_read_completes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> wr_o);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_o && !wr_o);
endmodule

// File: rtl/dma_reload_seq.sv
module dma_reload_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              irq_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] src_init, dst_init, src_ptr, dst_ptr;
  logic [LEN_W-1:0]  len;
  ctrl_t             ctrl;
  logic              clr, load, step, nxt, blk_end, en_clr;

  assign clr = reg_we_i && (reg_addr_i == REG_ICLR);

  dma_seq_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_clr_i(en_clr), .blk_end_i(blk_end), .clr_i(clr),
    .src_init_o(src_init), .dst_init_o(dst_init), .len_o(len),
    .ctrl_o(ctrl), .irq_o(irq_o)
  );

  dma_seq_ptr #(.ADDR_W(ADDR_W)) u_src (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .next_i(nxt),
    .reload_i(ctrl.rl_src), .init_i(src_init), .ptr_o(src_ptr)
  );

  dma_seq_ptr #(.ADDR_W(ADDR_W)) u_dst (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .next_i(nxt),
    .reload_i(ctrl.rl_dst), .init_i(dst_init), .ptr_o(dst_ptr)
  );

  dma_seq_ctrl #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .len_i(len), .clr_i(clr),
    .rdata_i(mem_rdata_i), .rd_o(mem_rd_o), .wr_o(mem_wr_o),
    .wdata_o(mem_wdata_o), .load_o(load), .step_o(step), .next_o(nxt),
    .blk_end_o(blk_end), .en_clr_o(en_clr), .done_o(done_o)
  );

  assign mem_addr_o = mem_rd_o ? src_ptr : dst_ptr;

  // a freshly raised stalling interrupt blocks the bus on the next cycle
  assert_stall_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && ctrl.int_en && ctrl.unmask && ctrl.en && !clr && !done_o
      |-> !mem_rd_o);
endmodule

// File: tb/dma_reload_seq_test.sv
module dma_reload_seq_test;
  import dma_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_rd, mem_wr, irq, done;

  always #2 clk = ~clk;

  dma_reload_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .irq_o(irq), .done_o(done)
  );

  function automatic logic [31:0] model_data(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  assign mem_rdata = model_data(mem_addr);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  typedef struct {
    bit          is_wr;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } item_t;
  item_t exp_q[$];

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push_block(logic [31:0] s, logic [31:0] d, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t r, w;
      r.is_wr = 1'b0; r.addr = s + i; r.data = '0; r.tag = tag;
      w.is_wr = 1'b1; w.addr = d + i; w.data = model_data(s + i); w.tag = tag;
      exp_q.push_back(r);
      exp_q.push_back(w);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    item_t it;
    if (rst_n && (mem_rd || mem_wr)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected bus access", mem_addr, 32'h0);
      end else begin
        it = exp_q.pop_front();
        check(mem_rd && !mem_wr && !it.is_wr || mem_wr && !mem_rd && it.is_wr,
              it.tag, "strobe kind", {31'd0, mem_wr}, {31'd0, it.is_wr});
        check(mem_addr == it.addr, it.tag, "address", mem_addr, it.addr);
        if (it.is_wr) check(mem_wdata == it.data, it.tag, "write data", mem_wdata, it.data);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_done(output int at);
    int k = 0;
    at = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    check(done, "R6", "done pulse seen", {31'd0, done}, 32'd1);
    at = cyc;
  endtask

  task automatic wait_irq();
    int k = 0;
    while (!irq && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic wait_writes(int n);
    int k = 0;
    while (k < n) begin @(negedge clk); if (mem_wr) k++; end
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!mem_rd && !mem_wr, tag, "bus idle", {30'd0, mem_rd, mem_wr}, 32'd0);
      check(!done, tag, "no done", {31'd0, done}, 32'd0);
    end
  endtask

  // two blocks with a stall between; reload bits cleared in the stall
  task automatic stall_case(logic [31:0] s, logic [31:0] d, int words, logic [31:0] c,
                            logic [31:0] s2, logic [31:0] d2, string tag);
    int t;
    reg_write(REG_SRC, s);
    reg_write(REG_DST, d);
    reg_write(REG_LEN, words - 1);
    push_block(s, d, words, tag);
    push_block(s2, d2, words, tag);
    reg_write(REG_CTRL, c);
    wait_irq();
    check(irq, "R9", "irq at block end", {31'd0, irq}, 32'd1);
    check(exp_q.size() == 2 * words, "R7", "items left at stall", exp_q.size(), 2 * words);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!mem_rd && !mem_wr, "R7", "stalled bus idle", {30'd0, mem_rd, mem_wr}, 32'd0);
      check(irq, "R9", "irq held in stall", {31'd0, irq}, 32'd1);
    end
    reg_write(REG_CTRL, 32'h19);
    quiet(2, "R7");
    reg_write(REG_ICLR, 32'h0);
    check(!irq, "R9", "irq cleared", {31'd0, irq}, 32'd0);
    check(mem_rd, "R7", "read after clear", {31'd0, mem_rd}, 32'd1);
    wait_done(t);
    @(negedge clk);
    check(exp_q.size() == 0, tag, "all items seen", exp_q.size(), 0);
    check(irq, "R9", "irq at final block end", {31'd0, irq}, 32'd1);
    reg_write(REG_ICLR, 32'h0);
  endtask

  initial begin
    int c0, cd;
    repeat (3) @(negedge clk);
    check(!mem_rd && !mem_wr, "R1", "strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!irq && !done, "R1", "irq/done after reset", {30'd0, irq, done}, 32'd0);
    quiet(4, "R1");

    // single block, no reload
    reg_write(REG_SRC, 32'h100);
    reg_write(REG_DST, 32'h200);
    reg_write(REG_LEN, 32'd2);
    push_block(32'h100, 32'h200, 3, "R3");
    reg_write(REG_CTRL, 32'h01);
    wait_done(cd);
    @(negedge clk);
    check(!done, "R6", "done one cycle", {31'd0, done}, 32'd0);
    check(exp_q.size() == 0, "R2", "single block words", exp_q.size(), 0);
    quiet(6, "R6");

    // stall mode, both reload / source only / destination only
    stall_case(32'h300, 32'h400, 2, 32'h1F, 32'h300, 32'h400, "R4");
    stall_case(32'h500, 32'h600, 3, 32'h1B, 32'h500, 32'h603, "R4");
    stall_case(32'h700, 32'h800, 3, 32'h1D, 32'h703, 32'h800, "R5");

    // back to back blocks, reload cleared while last block runs
    reg_write(REG_SRC, 32'h900);
    reg_write(REG_DST, 32'hA00);
    reg_write(REG_LEN, 32'd3);
    push_block(32'h900, 32'hA00, 4, "R11");
    push_block(32'h900, 32'hA00, 4, "R11");
    reg_write(REG_CTRL, 32'h07);
    while (!mem_rd) @(negedge clk);
    c0 = cyc;
    wait_writes(5);
    reg_we = 1'b1; reg_addr = REG_CTRL; reg_wdata = 32'h01;
    @(negedge clk);
    reg_we = 1'b0;
    wait_done(cd);
    check(cd - c0 == 16, "R8", "gapless cycles to done", cd - c0, 16);
    @(negedge clk);
    check(exp_q.size() == 0, "R11", "two blocks only", exp_q.size(), 0);

    // interrupt without stall, clear colliding with block end
    reg_write(REG_SRC, 32'hB00);
    reg_write(REG_DST, 32'hC00);
    reg_write(REG_LEN, 32'd1);
    for (int b = 0; b < 3; b++) push_block(32'hB00, 32'hC00, 2, "R9");
    reg_write(REG_CTRL, 32'h0F);
    wait_writes(3);
    check(irq, "R9", "irq high without stall", {31'd0, irq}, 32'd1);
    reg_we = 1'b1; reg_addr = REG_ICLR;
    @(negedge clk);
    reg_we = 1'b0;
    check(!irq, "R9", "mid-block clear", {31'd0, irq}, 32'd0);
    wait_writes(1);
    reg_we = 1'b1; reg_addr = REG_ICLR;
    @(negedge clk);
    reg_we = 1'b0;
    check(irq, "R9", "set wins over clear", {31'd0, irq}, 32'd1);
    check(mem_rd, "R8", "next block without gap", {31'd0, mem_rd}, 32'd1);
    reg_we = 1'b1; reg_addr = REG_CTRL; reg_wdata = 32'h09;
    @(negedge clk);
    reg_we = 1'b0;
    wait_done(cd);
    @(negedge clk);
    check(exp_q.size() == 0, "R9", "three blocks", exp_q.size(), 0);
    reg_write(REG_ICLR, 32'h0);

    // abort mid-block
    reg_write(REG_SRC, 32'hD00);
    reg_write(REG_DST, 32'hE00);
    reg_write(REG_LEN, 32'd3);
    push_block(32'hD00, 32'hE00, 2, "R10");
    reg_write(REG_CTRL, 32'h07);
    wait_writes(1);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = REG_CTRL; reg_wdata = 32'h06;
    @(negedge clk);
    reg_we = 1'b0;
    check(mem_wr, "R10", "in-flight write completes", {31'd0, mem_wr}, 32'd1);
    quiet(10, "R10");
    check(exp_q.size() == 0, "R10", "abort items", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule